// File: doc/BRIEF.md
# Parallel Reed-Solomon syndrome calculator

This block turns a received Reed-Solomon block over GF(2^8) into its syndrome vector. Received bytes arrive one per ready/valid transfer, with the highest-degree symbol first. For every byte, each syndrome term S_j, for j = 1 up to 2t, is folded in Horner fashion: S_j becomes the byte XOR (S_j times alpha^j). After the last byte of the block has been taken, the finished vector is placed on a ready/valid output. The next block can start streaming in at once.

The block length n and the syndrome count 2t are set at run time. They are held constant while a block is in progress. A static parameter sets how many terms are updated per clock, which trades multiplier area against input rate. The field's reducing polynomial is also a static parameter. A byte stays on the input, with its ready signal low, until every term for that byte has been updated. The downstream side can then pull the previous vector while a new one is being completed.

Top module: `rs_syndrome_calc`

## Requirements
- R1: After a synchronous reset, syn_valid is low and syn_vec is all zero. When 2t exceeds PAR, sym_ready is low until the first byte's terms are done.
- R2: For a block r_(n-1) .. r_0, sent in that order, the field byte syn_vec[8(j-1)+7 : 8(j-1)] holds S_j = sum of r_i * alpha^(i*j) for j = 1..2t.
- R3: A block that is a valid codeword produces an all-zero syndrome vector. Its generator has roots alpha^1 .. alpha^2t.
- R4: PAR terms are updated per clock, so with sym_valid held high a byte is accepted every ceil(2t/PAR) cycles. A block of n bytes takes n times that many cycles.
- R5: All terms are cleared when a vector is emitted, so each block's result is independent of the blocks before it.
- R6: Bytes of syn_vec for terms above 2t read zero.
- R7: While syn_valid is high and syn_ready is low, syn_vec and syn_valid hold steady.
- R8: When the last byte's final update group is reached while the output is still occupied, sym_ready stays low and no vector is lost.
- R9: A stalled completion goes through in the same cycle that syn_ready takes the old vector. The output then shows the new vector in the next cycle.
- R10: The block length n (2t < n <= 255) and the count 2t (even, 2..2*MAX_T) are honoured per block.
- R11: Field arithmetic uses XOR for addition and polynomial multiplication reduced by PRIM_POLY (default 0x11D), with alpha = 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_len | input | 8 | Symbols per block, n |
| chk_cnt | input | $clog2(2*MAX_T+1) | Number of syndromes, 2t |
| sym_valid | input | 1 | Received byte present |
| sym_data | input | 8 | Received byte |
| sym_ready | output | 1 | Received byte accepted this cycle |
| syn_valid | output | 1 | Syndrome vector present |
| syn_ready | input | 1 | Downstream takes the vector |
| syn_vec | output | 16*MAX_T | Syndrome vector, S_j in byte j-1 |

## Verification
Two events can fall in the same cycle: completing a new vector and handing the old vector downstream. To provoke this, the bench leaves one vector unread and streams a second block up to its last byte. It checks that this byte waits with sym_ready low while the old vector holds. It then raises syn_ready and checks that sym_ready rises in that same cycle. On the next cycle the output must show the second block's vector, with no gap and no loss.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    typedef logic [7:0] gf_t;

    typedef struct packed {
        logic step;
        logic consume;
        logic finish;
    } seq_ctl_t;

    function automatic gf_t gf_mul(input gf_t a, input gf_t b, input logic [8:0] poly);
        gf_t acc;
        gf_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ({x[6:0], 1'b0} ^ poly[7:0]) : {x[6:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic gf_t gf_alpha_pow(input int e, input logic [8:0] poly);
        gf_t p;
        p = 8'h01;
        for (int i = 0; i < e; i++) p = gf_mul(p, 8'h02, poly);
        return p;
    endfunction

endpackage

// File: rtl/rs_syn_lane.sv
module rs_syn_lane
    import rs_syn_pkg::*;
#(
    parameter logic [8:0] PRIM_POLY = 9'h11D
) (
    input  gf_t s_old,
    input  gf_t r_in,
    input  gf_t coef,
    output gf_t s_new
);
    assign s_new = r_in ^ gf_mul(s_old, coef, PRIM_POLY);
endmodule

// File: rtl/rs_syn_seq.sv
module rs_syn_seq
    import rs_syn_pkg::*;
#(
    parameter int NSYN = 32,
    parameter int PAR  = 4,
    parameter int CW   = $clog2(NSYN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    blk_len,
    input  logic [CW-1:0] chk_cnt,
    input  logic          sym_valid,
    input  logic          out_full,
    output logic [CW-1:0] grp_base,
    output seq_ctl_t      ctl,
    output logic          sym_ready
);
    logic [CW-1:0] grp_q;
    logic [7:0]    cnt_q;
    logic          final_grp;
    logic          last_sym;
    logic          blocked;

    assign final_grp = (int'(grp_q) + PAR) >= int'(chk_cnt);
    assign last_sym  = ({1'b0, cnt_q} + 9'd1) == {1'b0, blk_len};
    assign blocked   = final_grp && last_sym && out_full;

    assign ctl.step    = sym_valid && !blocked;
    assign ctl.consume = ctl.step && final_grp;
    assign ctl.finish  = ctl.consume && last_sym;
    assign sym_ready   = final_grp && !blocked;
    assign grp_base    = grp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
            cnt_q <= '0;
        end else if (ctl.step) begin
            if (final_grp) begin
                grp_q <= '0;
                cnt_q <= last_sym ? 8'd0 : cnt_q + 8'd1;
            end else begin
                grp_q <= grp_q + CW'(PAR);
            end
        end
    end

    // R4
    grp_bound_chk: assert property (@(posedge clk) disable iff (rst)
        grp_q < chk_cnt);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < blk_len);

endmodule

// File: rtl/rs_syn_outreg.sv
module rs_syn_outreg #(
    parameter int VW = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [VW-1:0] push_data,
    input  logic          syn_ready,
    output logic          syn_valid,
    output logic [VW-1:0] syn_vec,
    output logic          full
);
    assign full = syn_valid && !syn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_valid <= 1'b0;
            syn_vec   <= '0;
        end else if (push) begin
            syn_valid <= 1'b1;
            syn_vec   <= push_data;
        end else if (syn_ready) begin
            syn_valid <= 1'b0;
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (syn_valid && !syn_ready) |=> (syn_valid && $stable(syn_vec)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !(syn_valid && !syn_ready));

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
    import rs_syn_pkg::*;
#(
    parameter logic [8:0] PRIM_POLY = 9'h11D,
    parameter int         MAX_T     = 16,
    parameter int         PAR       = 4,
    localparam int        NSYN      = 2 * MAX_T,
    localparam int        CW        = $clog2(NSYN + 1),
    localparam int        IW        = $clog2(NSYN),
    localparam int        VW        = NSYN * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    blk_len,
    input  logic [CW-1:0] chk_cnt,
    input  logic          sym_valid,
    input  logic [7:0]    sym_data,
    output logic          sym_ready,
    output logic          syn_valid,
    input  logic          syn_ready,
    output logic [VW-1:0] syn_vec
);
    seq_ctl_t      ctl;
    logic [CW-1:0] grp_base;
    logic          out_full;
    logic [VW-1:0] push_vec;

    gf_t acc    [NSYN];
    gf_t acc_nx [NSYN];
    gf_t coef_tab [NSYN];

    logic [CW:0]   lane_pos [PAR];
    logic          lane_act [PAR];
    logic [IW-1:0] lane_sel [PAR];
    gf_t           lane_old [PAR];
    gf_t           lane_cf  [PAR];
    gf_t           lane_new [PAR];

    rs_syn_seq #(.NSYN(NSYN), .PAR(PAR), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .blk_len   (blk_len),
        .chk_cnt   (chk_cnt),
        .sym_valid (sym_valid),
        .out_full  (out_full),
        .grp_base  (grp_base),
        .ctl       (ctl),
        .sym_ready (sym_ready)
    );

    for (genvar k = 0; k < NSYN; k++) begin : g_coef
        localparam gf_t CF = gf_alpha_pow(k + 1, PRIM_POLY);
        assign coef_tab[k] = CF;
    end

    for (genvar l = 0; l < PAR; l++) begin : g_lane
        assign lane_pos[l] = {1'b0, grp_base} + (CW+1)'(l);
        assign lane_act[l] = ctl.step
                          && (lane_pos[l] < {1'b0, chk_cnt})
                          && (lane_pos[l] < (CW+1)'(NSYN));
        assign lane_sel[l] = lane_pos[l][IW-1:0];
        assign lane_old[l] = acc[lane_sel[l]];
        assign lane_cf[l]  = coef_tab[lane_sel[l]];

        rs_syn_lane #(.PRIM_POLY(PRIM_POLY)) u_lane (
            .s_old (lane_old[l]),
            .r_in  (sym_data),
            .coef  (lane_cf[l]),
            .s_new (lane_new[l])
        );
    end

    always_comb begin
        for (int k = 0; k < NSYN; k++) acc_nx[k] = acc[k];
        for (int l = 0; l < PAR; l++) begin
            if (lane_act[l]) acc_nx[lane_sel[l]] = lane_new[l];
        end
    end

    always_comb begin
        for (int k = 0; k < NSYN; k++) begin
            push_vec[k*8 +: 8] = (k < int'(chk_cnt)) ? acc_nx[k] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.finish) begin
            for (int k = 0; k < NSYN; k++) acc[k] <= '0;
        end else if (ctl.step) begin
            for (int k = 0; k < NSYN; k++) acc[k] <= acc_nx[k];
        end
    end

    rs_syn_outreg #(.VW(VW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.finish),
        .push_data (push_vec),
        .syn_ready (syn_ready),
        .syn_valid (syn_valid),
        .syn_vec   (syn_vec),
        .full      (out_full)
    );

    logic acc_nz;
    logic upper_nz;
    always_comb begin
        acc_nz   = 1'b0;
        upper_nz = 1'b0;
        for (int k = 0; k < NSYN; k++) begin
            if (acc[k] != 8'h00) acc_nz = 1'b1;
            if ((k >= int'(chk_cnt)) && (syn_vec[k*8 +: 8] != 8'h00)) upper_nz = 1'b1;
        end
    end

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.finish |=> !acc_nz);

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        syn_valid |-> !upper_nz);

endmodule

// File: tb/test_rs_syndrome_calc.sv
module test_rs_syndrome_calc;

    localparam int MAX_T = 16;
    localparam int LANES = 4;
    localparam int NSYN  = 2 * MAX_T;
    localparam int CW    = $clog2(NSYN + 1);
    localparam int VW    = NSYN * 8;
    localparam int NCFG  = 8;

    localparam int CFG_N   [NCFG] = '{255, 255, 255, 40, 40, 20, 12, 9};
    localparam int CFG_T2  [NCFG] = '{32,  32,  32,  8,  8,  4,  2,  6};
    localparam int CFG_ERR [NCFG] = '{0,   16,  5,   0,  4,  2,  1,  3};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    blk_len = 8'd0;
    logic [CW-1:0] chk_cnt = '0;
    logic          sym_valid = 1'b0;
    logic [7:0]    sym_data = 8'h00;
    logic          sym_ready;
    logic          syn_valid;
    logic          syn_ready = 1'b0;
    logic [VW-1:0] syn_vec;

    always #10 clk = ~clk;

    rs_syndrome_calc #(.PRIM_POLY(9'h11D), .MAX_T(MAX_T), .PAR(LANES)) i_rs_syndrome_calc (
        .clk       (clk),
        .rst       (rst),
        .blk_len   (blk_len),
        .chk_cnt   (chk_cnt),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .sym_ready (sym_ready),
        .syn_valid (syn_valid),
        .syn_ready (syn_ready),
        .syn_vec   (syn_vec)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]    gexp [0:511];
    int            glog [0:255];
    logic [7:0]    blk  [0:254];
    logic [VW-1:0] exp_vec;
    logic [VW-1:0] exp_a;
    int unsigned   rng;

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return gexp[glog[a] + glog[b]];
    endfunction

    function automatic logic [7:0] rnd8();
        rng = rng * 32'd1103515245 + 32'd12345;
        return rng[23:16];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic build_block(input int n, input int t2, input int nerr, input int seed);
        logic [7:0] g [0:32];
        logic [7:0] p [0:31];
        logic [7:0] fb;
        logic [7:0] s;
        int k;
        int pos;
        rng = seed;
        k = n - t2;
        for (int i = 0; i <= 32; i++) g[i] = 8'h00;
        g[0] = 8'h01;
        for (int j = 1; j <= t2; j++) begin
            for (int i = j; i >= 1; i--) g[i] = g[i-1] ^ fmul(g[i], gexp[j]);
            g[0] = fmul(g[0], gexp[j]);
        end
        for (int i = 0; i < 32; i++) p[i] = 8'h00;
        for (int i = 0; i < k; i++) begin
            blk[i] = rnd8();
            fb = blk[i] ^ p[t2-1];
            for (int m = t2 - 1; m >= 1; m--) p[m] = p[m-1] ^ fmul(fb, g[m]);
            p[0] = fmul(fb, g[0]);
        end
        for (int i = 0; i < t2; i++) blk[k+i] = p[t2-1-i];
        for (int e = 0; e < nerr; e++) begin
            pos = (e * (n / nerr) + 1) % n;
            blk[pos] = blk[pos] ^ (rnd8() | 8'h01);
        end
        exp_vec = '0;
        for (int j = 1; j <= t2; j++) begin
            s = 8'h00;
            for (int i = 0; i < n; i++) s = fmul(s, gexp[j]) ^ blk[i];
            exp_vec[(j-1)*8 +: 8] = s;
        end
    endtask

    task automatic send(input int cnt, output int cyc);
        bit got;
        cyc = 0;
        for (int i = 0; i < cnt; i++) begin
            sym_data  = blk[i];
            sym_valid = 1'b1;
            do begin
                #1 got = sym_ready;
                @(negedge clk);
                cyc++;
            end while (!got);
        end
        sym_valid = 1'b0;
    endtask

    task automatic drain();
        syn_ready = 1'b1;
        @(negedge clk);
        syn_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        int grp;
        logic [VW-1:0] upper_mask;

        gexp[0] = 8'h01;
        for (int i = 1; i < 512; i++)
            gexp[i] = gexp[i-1][7] ? ({gexp[i-1][6:0], 1'b0} ^ 8'h1D) : {gexp[i-1][6:0], 1'b0};
        for (int i = 0; i < 256; i++) glog[i] = 0;
        for (int i = 0; i < 255; i++) glog[gexp[i]] = i;

        blk_len = 8'd255;
        chk_cnt = CW'(32);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(syn_valid == 1'b0, "R1", "syn_valid after reset", VW'(syn_valid), '0);
        chk(syn_vec == '0, "R1", "syn_vec after reset", syn_vec, '0);
        chk(sym_ready == 1'b0, "R1", "sym_ready after reset", VW'(sym_ready), '0);
        @(negedge clk);

        for (int c = 0; c < NCFG; c++) begin
            blk_len = 8'(CFG_N[c]);
            chk_cnt = CW'(CFG_T2[c]);
            build_block(CFG_N[c], CFG_T2[c], CFG_ERR[c], 17 + 31 * c);
            send(CFG_N[c], cyc);
            grp = (CFG_T2[c] + LANES - 1) / LANES;
            // R4 cycles per block
            chk(cyc == CFG_N[c] * grp, "R4", "cycles for block", VW'(cyc), VW'(CFG_N[c] * grp));
            chk(syn_valid == 1'b1, "R2", "syn_valid after last byte", VW'(syn_valid), VW'(1));
            // R2 R5 R10 R11 syndrome values vs model
            chk(syn_vec == exp_vec, "R2 R5 R10 R11", "syndrome vector", syn_vec, exp_vec);
            if (CFG_ERR[c] == 0)
                // R3 clean codeword
                chk(syn_vec == '0, "R3", "codeword syndromes", syn_vec, '0);
            if (CFG_T2[c] < NSYN) begin
                upper_mask = '1;
                upper_mask = upper_mask << (CFG_T2[c] * 8);
                // R6 unused terms
                chk((syn_vec & upper_mask) == '0, "R6", "upper bytes", syn_vec & upper_mask, '0);
            end
            drain();
            chk(syn_valid == 1'b0, "R7", "syn_valid after pop", VW'(syn_valid), '0);
        end

        // Overlap: completion stalled behind an unread vector, then push and pop together
        blk_len = 8'd10;
        chk_cnt = CW'(8);
        build_block(10, 8, 2, 901);
        exp_a = exp_vec;
        send(10, cyc);
        chk(syn_vec == exp_a, "R2", "first overlap vector", syn_vec, exp_a);
        build_block(10, 8, 1, 477);
        send(9, cyc);
        sym_data  = blk[9];
        sym_valid = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        // R8 last byte waits while output occupied
        chk(sym_ready == 1'b0, "R8", "sym_ready while full", VW'(sym_ready), '0);
        // R7 held vector
        chk(syn_valid == 1'b1 && syn_vec == exp_a, "R7", "held vector", syn_vec, exp_a);
        syn_ready = 1'b1;
        #1;
        // R9 same-cycle acceptance
        chk(sym_ready == 1'b1, "R9", "sym_ready with pop", VW'(sym_ready), VW'(1));
        @(negedge clk);
        sym_valid = 1'b0;
        syn_ready = 1'b0;
        #1;
        chk(syn_valid == 1'b1 && syn_vec == exp_vec, "R9", "vector after overlap", syn_vec, exp_vec);
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule